// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, records which ones are pending and which are being serviced, and signals a processor through one interrupt output. Software talks to it through two addresses. The command address takes the start-of-setup word, end-of-interrupt commands and a choice of which status register to read back. The data address takes the setup words and the mask. A one-cycle acknowledge pulse returns an 8-bit vector for the winning line and moves that line from pending to in service.

After reset or on a setup command, the block expects three data writes, in this order: the vector base, a cascade word (a bitmask of slave-bearing inputs on a master, or an identity number on a slave), and a mode word that can turn on automatic end-of-interrupt. Priority is fixed, with line 0 highest. A request that is no longer present at acknowledge time is answered with the level-7 vector and leaves no trace in the in-service register, so software can recognise it as spurious.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, pending and in-service registers are zero, command reads return the pending register, the cascade word is 0x00 and `int_out` is low.
- R2: A command write of exactly 0x11 clears the mask and the in-service register, selects the pending register for command reads, and makes the next three data writes setup words; until the third one `int_out` stays low and data writes leave the mask unchanged.
- R3: An acknowledge that grants line n returns base + n (8-bit sum), where base is the first setup word.
- R4: The second setup word appears unchanged on `casc_word`.
- R5: When bit 1 of the third setup word is 1, an acknowledge leaves the in-service register unchanged.
- R6: Outside setup, a data write loads the mask, a 1 bit blocks that line from raising `int_out`, and a data read returns the mask exactly.
- R7: A command write of 0x0B makes command reads return the in-service register; 0x0A returns them to the pending register.
- R8: `int_out` is high only when some unmasked pending line has a lower index than every in-service line; among several, the lowest index wins the acknowledge.
- R9: A pending bit is set by a rising edge on its line and cleared when the line is low; a line held high after its acknowledge raises no new request.
- R10: An acknowledge that grants line n clears pending bit n and, without auto end-of-interrupt, sets in-service bit n.
- R11: A command write of 0x60 + n (n from 0 to 7) clears in-service bit n and no other bit.
- R12: An acknowledge with no eligible request returns base + 7 and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 selects the command address, 1 the data address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the address on `addr` |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle interrupt acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| ack_vec | output | 8 | Vector returned during the acknowledge cycle |
| casc_word | output | 8 | Stored cascade setup word |

## Verification
The assertions assume `ack` is a single-cycle pulse, that a write and an acknowledge may share a cycle only as the design defines, and that request lines stay low through reset so that no edge is seen on the first cycle. The stimulus changes lines, strobes and acknowledges only on falling clock edges, holds every request high until it has been acknowledged unless the test is about a vanished request, and always completes the three setup writes before checking normal operation.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NUM_LINES = 8;
  localparam int LVL_W     = $clog2(NUM_LINES);
  localparam int DW        = 8;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_BASE, SEQ_CASC, SEQ_MODE} seq_t;

  localparam logic [DW-1:0] CMD_START  = 8'h11;
  localparam logic [DW-1:0] CMD_RD_IRR = 8'h0A;
  localparam logic [DW-1:0] CMD_RD_ISR = 8'h0B;
  localparam logic [4:0]    CMD_EOI_HI = 5'b01100;

  // {valid, index} of the lowest set bit (highest priority)
  function automatic logic [LVL_W:0] lead_pick(input logic [NUM_LINES-1:0] v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, LVL_W'(i)};
    return r;
  endfunction

  function automatic logic [DW-1:0] vec_of(input logic [DW-1:0] base,
                                           input logic [LVL_W-1:0] lvl);
    return base + DW'(lvl);
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq import pic_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          start,
  output logic          mask_load,
  output logic [DW-1:0] base,
  output logic [DW-1:0] casc,
  output logic          aeoi
);
  seq_t st;

  assign start     = cmd_wr && (wdata == CMD_START);
  assign busy      = (st != SEQ_IDLE);
  assign mask_load = data_wr && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SEQ_IDLE;
      base <= '0;
      casc <= '0;
      aeoi <= 1'b0;
    end else if (start) begin
      st <= SEQ_BASE;
    end else if (data_wr) begin
      case (st)
        SEQ_BASE: begin base <= wdata; st <= SEQ_CASC; end
        SEQ_CASC: begin casc <= wdata; st <= SEQ_MODE; end
        SEQ_MODE: begin aeoi <= wdata[1]; st <= SEQ_IDLE; end
        default:  st <= SEQ_IDLE;
      endcase
    end
  end

  assert_seq_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch import pic_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] clr,
  output logic [NUM_LINES-1:0] irr
);
  logic [NUM_LINES-1:0] prev;
  logic [NUM_LINES-1:0] irr_nxt;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign irr_nxt[g] = irq_in[g] && (irr[g] || !prev[g]) && !clr[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      irr  <= irr_nxt;
    end
  end

  assert_irr_follows_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irr & ~$past(irq_in)) == '0);
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver import pic_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ready,
  input  logic [NUM_LINES-1:0] irr,
  input  logic [NUM_LINES-1:0] imr,
  input  logic [NUM_LINES-1:0] isr,
  input  logic [DW-1:0]        base,
  output logic                 win,
  output logic [LVL_W-1:0]     win_lvl,
  output logic [NUM_LINES-1:0] grant,
  output logic [DW-1:0]        vec
);
  logic [LVL_W:0] p_pick, s_pick;

  assign p_pick  = lead_pick(irr & ~imr);
  assign s_pick  = lead_pick(isr);
  assign win_lvl = p_pick[LVL_W-1:0];
  assign win     = ready && p_pick[LVL_W] &&
                   (!s_pick[LVL_W] || (p_pick[LVL_W-1:0] < s_pick[LVL_W-1:0]));
  assign grant   = win ? (NUM_LINES'(1) << win_lvl) : '0;
  assign vec     = win ? vec_of(base, win_lvl) : vec_of(base, LVL_W'(NUM_LINES - 1));

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & imr) == '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import pic_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_data,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 ack,
  output logic                 int_out,
  output logic [DW-1:0]        ack_vec,
  output logic [DW-1:0]        casc_word
);
  logic cmd_wr, data_wr;
  logic busy, start, mask_load, aeoi;
  logic [DW-1:0] base;
  logic [NUM_LINES-1:0] imr, isr, irr, grant, irr_clr, isr_set, eoi_mask;
  logic sel_isr, win, eoi_fire, ack_take;
  logic [LVL_W-1:0] win_lvl, eoi_lvl;

  assign cmd_wr   = wr_en && !addr;
  assign data_wr  = wr_en && addr;
  assign eoi_fire = cmd_wr && (wr_data[7:3] == CMD_EOI_HI);
  assign eoi_lvl  = wr_data[LVL_W-1:0];
  assign eoi_mask = eoi_fire ? (NUM_LINES'(1) << eoi_lvl) : '0;
  assign ack_take = ack && win;
  assign irr_clr  = ack_take ? grant : '0;
  assign isr_set  = (ack_take && !aeoi) ? grant : '0;

  pic_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .wdata(wr_data), .busy(busy), .start(start), .mask_load(mask_load),
    .base(base), .casc(casc_word), .aeoi(aeoi));

  pic_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(irr_clr), .irr(irr));

  pic_resolver u_res (
    .clk(clk), .rst_n(rst_n), .ready(!busy), .irr(irr), .imr(imr), .isr(isr),
    .base(base), .win(win), .win_lvl(win_lvl), .grant(grant), .vec(ack_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr     <= '1;
      isr     <= '0;
      sel_isr <= 1'b0;
    end else if (start) begin
      imr     <= '0;
      isr     <= '0;
      sel_isr <= 1'b0;
    end else begin
      if (mask_load) imr <= wr_data;
      isr <= (isr & ~eoi_mask) | isr_set;
      if (cmd_wr && wr_data == CMD_RD_ISR) sel_isr <= 1'b1;
      else if (cmd_wr && wr_data == CMD_RD_IRR) sel_isr <= 1'b0;
    end
  end

  assign int_out = win;
  assign rd_data = addr ? imr : (sel_isr ? isr : irr);

  assert_init_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !int_out);
  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !busy) |=> (imr == $past(wr_data)));
  assert_aeoi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi && !cmd_wr) |=> $stable(isr));
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !irr[$past(win_lvl)]);
  assert_eoi_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !ack) |=> !isr[$past(eoi_lvl)]);
  assert_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !win && !cmd_wr) |=> $stable(isr));
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] irq_in = '0;
  logic ack = 1'b0;
  logic int_out;
  logic [7:0] ack_vec;
  logic [7:0] casc_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_in(irq_in), .ack(ack), .int_out(int_out),
    .ack_vec(ack_vec), .casc_word(casc_word));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wrt(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
    @(negedge clk);
    #1;
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    #1;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (ack) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL unexpected ack actual=%02h expected=none", ack_vec);
        end else begin
          chk(tag_q.pop_front(), ack_vec, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 int_out", {7'b0, int_out}, 8'h00);
    rd(1'b1, v); chk("R1 mask", v, 8'hFF);
    rd(1'b0, v); chk("R1 irr", v, 8'h00);
    chk("R1 casc", casc_word, 8'h00);

    wrt(1'b0, 8'h11);
    rd(1'b1, v); chk("R2 mask cleared", v, 8'h00);
    wrt(1'b1, 8'h20);
    line(3, 1'b1);
    chk("R2 quiet in setup", {7'b0, int_out}, 8'h00);
    rd(1'b1, v); chk("R2 mask untouched", v, 8'h00);
    wrt(1'b1, 8'h04);
    wrt(1'b1, 8'h01);
    #1;
    chk("R8 int raised", {7'b0, int_out}, 8'h01);
    chk("R4 casc", casc_word, 8'h04);
    rd(1'b0, v); chk("R9 irr latched", v, 8'h08);

    do_ack("R3 R10 vec line3", 8'h23);
    chk("R8 int low", {7'b0, int_out}, 8'h00);
    wrt(1'b0, 8'h0B);
    rd(1'b0, v); chk("R7 R10 isr", v, 8'h08);
    wrt(1'b0, 8'h0A);
    rd(1'b0, v); chk("R7 R10 irr cleared", v, 8'h00);
    wrt(1'b0, 8'h0B);

    line(5, 1'b1);
    chk("R8 lower blocked", {7'b0, int_out}, 8'h00);
    line(1, 1'b1);
    chk("R8 higher wins", {7'b0, int_out}, 8'h01);
    do_ack("R3 vec line1", 8'h21);
    rd(1'b0, v); chk("R10 isr nested", v, 8'h0A);

    wrt(1'b0, 8'h61);
    rd(1'b0, v); chk("R11 eoi 1", v, 8'h08);
    chk("R8 still blocked", {7'b0, int_out}, 8'h00);
    wrt(1'b0, 8'h63);
    rd(1'b0, v); chk("R11 eoi 3", v, 8'h00);
    chk("R8 line5 now", {7'b0, int_out}, 8'h01);
    do_ack("R3 vec line5", 8'h25);
    rd(1'b0, v); chk("R10 isr line5", v, 8'h20);
    wrt(1'b0, 8'h65);
    rd(1'b0, v); chk("R11 eoi 5", v, 8'h00);
    chk("R9 held lines quiet", {7'b0, int_out}, 8'h00);

    @(negedge clk); irq_in = '0;
    wrt(1'b1, 8'hFF);
    rd(1'b1, v); chk("R6 mask readback", v, 8'hFF);
    line(2, 1'b1);
    chk("R6 masked quiet", {7'b0, int_out}, 8'h00);
    wrt(1'b0, 8'h0A);
    rd(1'b0, v); chk("R9 masked pending", v, 8'h04);
    wrt(1'b1, 8'hFB);
    #1;
    chk("R6 unmask raises", {7'b0, int_out}, 8'h01);
    rd(1'b1, v); chk("R6 mask FB", v, 8'hFB);

    line(2, 1'b0);
    chk("R9 drop clears", {7'b0, int_out}, 8'h00);
    rd(1'b0, v); chk("R9 irr empty", v, 8'h00);
    do_ack("R12 spurious vec", 8'h27);
    wrt(1'b0, 8'h0B);
    rd(1'b0, v); chk("R12 isr untouched", v, 8'h00);

    line(2, 1'b1);
    do_ack("R3 vec line2", 8'h22);
    rd(1'b0, v); chk("R10 isr line2", v, 8'h04);
    wrt(1'b0, 8'h62);
    rd(1'b0, v); chk("R11 eoi 2", v, 8'h00);
    chk("R9 no re-request", {7'b0, int_out}, 8'h00);

    wrt(1'b0, 8'h11);
    wrt(1'b1, 8'h40);
    wrt(1'b1, 8'h02);
    wrt(1'b1, 8'h03);
    chk("R4 slave id", casc_word, 8'h02);
    line(6, 1'b1);
    chk("R8 aeoi raise", {7'b0, int_out}, 8'h01);
    do_ack("R3 vec base40", 8'h46);
    wrt(1'b0, 8'h0B);
    rd(1'b0, v); chk("R5 aeoi isr", v, 8'h00);
    @(negedge clk); irq_in[0] = 1'b1; irq_in[4] = 1'b1;
    @(negedge clk); #1;
    do_ack("R8 lowest index first", 8'h40);
    do_ack("R8 next line", 8'h44);
    rd(1'b0, v); chk("R5 isr stays clear", v, 8'h00);

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending acks actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule